// File: doc/BRIEF.md
# Indirect pointer address generator

This block turns one of three 16-bit pointer values, kept in a register file outside it, into the effective address of an indirect memory access. It also computes the updated pointer value that the register file must store. A strobe presents the selector, the access mode and the pointer values. One cycle later the block returns four things: the address, whether it targets data space or program space, the write-back value with its enable and the pointer it belongs to, and an error flag for combinations that are not allowed.

Data-space modes are: plain indirect, use-then-increment, decrement-then-use, and pointer plus an unsigned displacement. Program-space modes always use pointer Z: byte read, byte read with increment, extended read through a 24-bit address formed from an 8-bit extension byte above Z, that extended read with a 24-bit increment, and word store with an increment of two. Instruction decode and the memories themselves sit outside the block.

Top module: `ptr_addr_gen`

## Requirements
- R1: While rst_ni is low and after its release with no strobe, valid_o, err_o, wb_en_o and wb_ext_en_o are 0.
- R2: A strobe on start_i in one cycle gives exactly one cycle of valid_o (or err_o) in the next cycle. Without a strobe, valid_o, err_o and both write-back enables stay 0.
- R3: Mode code 0 (plain indirect) outputs the selected pointer as the address in data space (prog_o=0) and has no write-back. Selector codes: 0 = X, 1 = Y, 2 = Z, 3 = reserved (error in every data-space mode).
- R4: Mode code 1 (use-then-increment) addresses the pointer's old value and writes back pointer+1 modulo 2^16 to the selected pointer.
- R5: Mode code 2 (decrement-then-use) addresses pointer−1 modulo 2^16 and writes that same value back.
- R6: Mode code 3 (displacement) addresses (pointer + zero-extended 6-bit q) modulo 2^16 and has no write-back. With selector X it raises err_o with no valid_o and no write-back.
- R7: Mode codes 4 and 5 (program byte read) address {8'h00, Z} in program space (prog_o=1) whatever the selector. Code 5 writes back Z+1 modulo 2^16 to Z with wb_ext_en_o=0.
- R8: Mode codes 6 and 7 (extended read) address {ext_i, Z} in program space. Code 7 increments that 24-bit value: wb_val_o gets its low 16 bits and wb_ext_o its high byte, with wb_ext_en_o=1, so a carry out of Z reaches the extension byte.
- R9: Mode code 8 (word store) addresses {ext_i, Z[15:1], 0} in program space and writes back Z+2 modulo 2^16 with the extension byte unchanged.
- R10: Mode codes 9 to 15 raise err_o with no valid_o and no write-back.
- R11: wb_sel_o names the pointer to update: the selector in data-space modes, 2 (Z) in program-space modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| sel_i | input | 2 | Pointer selector |
| mode_i | input | 4 | Access mode code |
| disp_i | input | 6 | Unsigned displacement q |
| ptr_x_i | input | 16 | Current X value |
| ptr_y_i | input | 16 | Current Y value |
| ptr_z_i | input | 16 | Current Z value |
| ext_i | input | 8 | Extension byte above Z |
| valid_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Illegal request pulse |
| addr_o | output | 24 | Effective byte address |
| prog_o | output | 1 | 1 = program space, 0 = data space |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_sel_o | output | 2 | Pointer to update |
| wb_val_o | output | 16 | New pointer value |
| wb_ext_en_o | output | 1 | Extension byte write-back enable |
| wb_ext_o | output | 8 | New extension byte |

## Verification
The hardest case to reach is the carry from Z into the extension byte during an extended read with increment. It only shows when Z is exactly 0xFFFF, and the full 24-bit wrap needs the extension byte at 0xFF as well. The stimulus sets both edge values directly. It also runs the case where the extension byte is non-zero and Z is not at its limit, so that a carry wrongly kept or wrongly dropped would show in wb_ext_o. The 16-bit wraps of the other modes are forced the same way, with pointers at 0x0000, 0xFFFF and 0xFFFE.

// File: rtl/ag_pkg.sv
package ag_pkg;
  typedef enum logic [3:0] {
    M_IND     = 4'd0,
    M_POST    = 4'd1,
    M_PRE     = 4'd2,
    M_DISP    = 4'd3,
    M_PRD     = 4'd4,
    M_PRD_INC = 4'd5,
    M_XRD     = 4'd6,
    M_XRD_INC = 4'd7,
    M_WST_INC = 4'd8
  } ag_mode_e;

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_Z = 2'd2;
endpackage

// File: rtl/ag_ptr_select.sv
module ag_ptr_select #(
  parameter int PTR_W = 16
) (
  input  logic [1:0]       sel_i,
  input  logic [PTR_W-1:0] ptr_x_i,
  input  logic [PTR_W-1:0] ptr_y_i,
  input  logic [PTR_W-1:0] ptr_z_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sel_bad_o,
  output logic             sel_x_o
);
  always_comb begin
    sel_bad_o = 1'b0;
    unique case (sel_i)
      ag_pkg::SEL_X: ptr_o = ptr_x_i;
      ag_pkg::SEL_Y: ptr_o = ptr_y_i;
      ag_pkg::SEL_Z: ptr_o = ptr_z_i;
      default: begin
        ptr_o     = '0;
        sel_bad_o = 1'b1;
      end
    endcase
  end
  assign sel_x_o = (sel_i == ag_pkg::SEL_X);
endmodule

// File: rtl/ag_addr_calc.sv
module ag_addr_calc #(
  parameter int PTR_W  = 16,
  parameter int EXT_W  = 8,
  parameter int DISP_W = 6,
  localparam int ADDR_W = PTR_W + EXT_W
) (
  input  logic [3:0]        mode_i,
  input  logic [1:0]        sel_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              sel_bad_i,
  input  logic              sel_x_i,
  input  logic [PTR_W-1:0]  ptr_z_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              prog_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_sel_o,
  output logic [PTR_W-1:0]  wb_val_o,
  output logic              wb_ext_en_o,
  output logic [EXT_W-1:0]  wb_ext_o,
  output logic              err_o
);
  import ag_pkg::*;

  localparam logic [EXT_W-1:0] EXT_ZERO = '0;

  logic [PTR_W-1:0]  ptr_inc, ptr_dec, disp_sum, z_inc1, z_inc2;
  logic [ADDR_W-1:0] ext_inc;
  logic              wb_raw;

  assign ptr_inc  = ptr_i + PTR_W'(1);
  assign ptr_dec  = ptr_i - PTR_W'(1);
  assign disp_sum = ptr_i + PTR_W'(disp_i);
  assign z_inc1   = ptr_z_i + PTR_W'(1);
  assign z_inc2   = ptr_z_i + PTR_W'(2);
  assign ext_inc  = {ext_i, ptr_z_i} + ADDR_W'(1);

  always_comb begin
    addr_o      = {EXT_ZERO, ptr_i};
    prog_o      = 1'b0;
    wb_raw      = 1'b0;
    wb_sel_o    = sel_i;
    wb_val_o    = ptr_i;
    wb_ext_en_o = 1'b0;
    wb_ext_o    = ext_i;
    err_o       = 1'b0;
    case (mode_i)
      M_IND: err_o = sel_bad_i;
      M_POST: begin
        wb_raw   = 1'b1;
        wb_val_o = ptr_inc;
        err_o    = sel_bad_i;
      end
      M_PRE: begin
        addr_o   = {EXT_ZERO, ptr_dec};
        wb_raw   = 1'b1;
        wb_val_o = ptr_dec;
        err_o    = sel_bad_i;
      end
      M_DISP: begin
        addr_o = {EXT_ZERO, disp_sum};
        err_o  = sel_bad_i | sel_x_i;
      end
      M_PRD, M_PRD_INC: begin
        addr_o   = {EXT_ZERO, ptr_z_i};
        prog_o   = 1'b1;
        wb_sel_o = SEL_Z;
        wb_raw   = (mode_i == M_PRD_INC);
        wb_val_o = z_inc1;
      end
      M_XRD, M_XRD_INC: begin
        addr_o   = {ext_i, ptr_z_i};
        prog_o   = 1'b1;
        wb_sel_o = SEL_Z;
        wb_raw   = (mode_i == M_XRD_INC);
        wb_val_o = ext_inc[PTR_W-1:0];
        wb_ext_o = ext_inc[ADDR_W-1:PTR_W];
        wb_ext_en_o = (mode_i == M_XRD_INC);
      end
      M_WST_INC: begin
        addr_o   = {ext_i, ptr_z_i[PTR_W-1:1], 1'b0};
        prog_o   = 1'b1;
        wb_sel_o = SEL_Z;
        wb_raw   = 1'b1;
        wb_val_o = z_inc2;
      end
      default: err_o = 1'b1;
    endcase
    wb_en_o = wb_raw & ~err_o;
    if (err_o) wb_ext_en_o = 1'b0;
  end
endmodule

// File: rtl/ag_out_reg.sv
module ag_out_reg #(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8,
  localparam int ADDR_W = PTR_W + EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_i,
  input  logic              wb_en_i,
  input  logic [1:0]        wb_sel_i,
  input  logic [PTR_W-1:0]  wb_val_i,
  input  logic              wb_ext_en_i,
  input  logic [EXT_W-1:0]  wb_ext_i,
  input  logic              err_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              prog_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_sel_o,
  output logic [PTR_W-1:0]  wb_val_o,
  output logic              wb_ext_en_o,
  output logic [EXT_W-1:0]  wb_ext_o
);
  // strobes pulse for one cycle; payload holds until the next request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
      wb_en_o     <= 1'b0;
      wb_ext_en_o <= 1'b0;
    end else begin
      valid_o     <= start_i & ~err_i;
      err_o       <= start_i & err_i;
      wb_en_o     <= start_i & wb_en_i;
      wb_ext_en_o <= start_i & wb_ext_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      prog_o   <= 1'b0;
      wb_sel_o <= '0;
      wb_val_o <= '0;
      wb_ext_o <= '0;
    end else if (start_i) begin
      addr_o   <= addr_i;
      prog_o   <= prog_i;
      wb_sel_o <= wb_sel_i;
      wb_val_o <= wb_val_i;
      wb_ext_o <= wb_ext_i;
    end
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int PTR_W  = 16,
  parameter int EXT_W  = 8,
  parameter int DISP_W = 6,
  localparam int ADDR_W = PTR_W + EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        sel_i,
  input  logic [3:0]        mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PTR_W-1:0]  ptr_x_i,
  input  logic [PTR_W-1:0]  ptr_y_i,
  input  logic [PTR_W-1:0]  ptr_z_i,
  input  logic [EXT_W-1:0]  ext_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              prog_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_sel_o,
  output logic [PTR_W-1:0]  wb_val_o,
  output logic              wb_ext_en_o,
  output logic [EXT_W-1:0]  wb_ext_o
);
  logic [PTR_W-1:0]  ptr_sel;
  logic              sel_bad, sel_x;
  logic [ADDR_W-1:0] c_addr;
  logic              c_prog, c_wb_en, c_wb_ext_en, c_err;
  logic [1:0]        c_wb_sel;
  logic [PTR_W-1:0]  c_wb_val;
  logic [EXT_W-1:0]  c_wb_ext;

  ag_ptr_select #(.PTR_W(PTR_W)) u_sel (
    .sel_i(sel_i), .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i), .ptr_z_i(ptr_z_i),
    .ptr_o(ptr_sel), .sel_bad_o(sel_bad), .sel_x_o(sel_x)
  );

  ag_addr_calc #(.PTR_W(PTR_W), .EXT_W(EXT_W), .DISP_W(DISP_W)) u_calc (
    .mode_i(mode_i), .sel_i(sel_i), .ptr_i(ptr_sel), .sel_bad_i(sel_bad),
    .sel_x_i(sel_x), .ptr_z_i(ptr_z_i), .ext_i(ext_i), .disp_i(disp_i),
    .addr_o(c_addr), .prog_o(c_prog), .wb_en_o(c_wb_en), .wb_sel_o(c_wb_sel),
    .wb_val_o(c_wb_val), .wb_ext_en_o(c_wb_ext_en), .wb_ext_o(c_wb_ext),
    .err_o(c_err)
  );

  ag_out_reg #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .addr_i(c_addr), .prog_i(c_prog), .wb_en_i(c_wb_en), .wb_sel_i(c_wb_sel),
    .wb_val_i(c_wb_val), .wb_ext_en_i(c_wb_ext_en), .wb_ext_i(c_wb_ext),
    .err_i(c_err),
    .valid_o(valid_o), .err_o(err_o), .addr_o(addr_o), .prog_o(prog_o),
    .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_val_o(wb_val_o),
    .wb_ext_en_o(wb_ext_en_o), .wb_ext_o(wb_ext_o)
  );

  assert_strobe_answer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o ^ err_o));
  assert_quiet_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o && !err_o && !wb_en_o);
  assert_err_blocks_wb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o && !wb_en_o && !wb_ext_en_o);
  assert_ext_wb_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ext_en_o |-> wb_en_o && prog_o && wb_sel_o == ag_pkg::SEL_Z);
  assert_disp_x_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 4'd3 && sel_i == ag_pkg::SEL_X) |=> err_o);
  assert_prog_uses_z_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && prog_o && wb_en_o) |-> wb_sel_o == ag_pkg::SEL_Z);
  assert_wst_even_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 4'd8) |=> !addr_o[0]);
endmodule

// File: tb/ptr_addr_gen_bench.sv
module ptr_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  sel_i = '0;
  logic [3:0]  mode_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] ptr_x_i = '0, ptr_y_i = '0, ptr_z_i = '0;
  logic [7:0]  ext_i = '0;
  logic        valid_o, err_o, prog_o, wb_en_o, wb_ext_en_o;
  logic [23:0] addr_o;
  logic [1:0]  wb_sel_o;
  logic [15:0] wb_val_o;
  logic [7:0]  wb_ext_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ptr_addr_gen u_ptr_addr_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, launch on posedge, sample at the following negedge
  task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic [5:0] q);
    @(negedge clk_i);
    mode_i = m; sel_i = s; disp_i = q; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic expect_ok(input string req, input logic [23:0] a, input logic p,
                           input logic we, input logic [1:0] ws, input logic [15:0] wv,
                           input logic wee, input logic [7:0] wx);
    chk({req, " valid"}, {31'd0, valid_o}, 32'd1);
    chk({req, " err"}, {31'd0, err_o}, 32'd0);
    chk({req, " addr"}, {8'd0, addr_o}, {8'd0, a});
    chk({req, " prog"}, {31'd0, prog_o}, {31'd0, p});
    chk({req, " wb_en"}, {31'd0, wb_en_o}, {31'd0, we});
    chk({req, " wb_ext_en"}, {31'd0, wb_ext_en_o}, {31'd0, wee});
    if (we) begin
      chk({req, " wb_sel"}, {30'd0, wb_sel_o}, {30'd0, ws});
      chk({req, " wb_val"}, {16'd0, wb_val_o}, {16'd0, wv});
    end
    if (wee) chk({req, " wb_ext"}, {24'd0, wb_ext_o}, {24'd0, wx});
  endtask

  task automatic expect_err(input string req);
    chk({req, " err"}, {31'd0, err_o}, 32'd1);
    chk({req, " valid"}, {31'd0, valid_o}, 32'd0);
    chk({req, " wb_en"}, {31'd0, wb_en_o}, 32'd0);
    chk({req, " wb_ext_en"}, {31'd0, wb_ext_en_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    chk("R1 wb_en in reset", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after reset", {31'd0, valid_o}, 32'd0);
    chk("R1 err after reset", {31'd0, err_o}, 32'd0);
    chk("R1 wb_ext_en after reset", {31'd0, wb_ext_en_o}, 32'd0);
  endtask

  task automatic t_pulse;
    ptr_y_i = 16'h4000;
    issue(4'd1, 2'd1, 6'd0);
    expect_ok("R2 first", 24'h004000, 1'b0, 1'b1, 2'd1, 16'h4001, 1'b0, 8'h00);
    @(negedge clk_i);
    chk("R2 valid drops", {31'd0, valid_o}, 32'd0);
    chk("R2 wb_en drops", {31'd0, wb_en_o}, 32'd0);
  endtask

  task automatic t_plain;
    ptr_x_i = 16'h1357; ptr_y_i = 16'h2468; ptr_z_i = 16'hABCD;
    issue(4'd0, 2'd0, 6'd5);
    expect_ok("R3 X", 24'h001357, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0);
    issue(4'd0, 2'd2, 6'd0);
    expect_ok("R3 Z", 24'h00ABCD, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0);
    issue(4'd0, 2'd3, 6'd0);
    expect_err("R3 reserved selector");
  endtask

  task automatic t_post;
    ptr_x_i = 16'hFFFF;
    issue(4'd1, 2'd0, 6'd0);
    expect_ok("R4 wrap", 24'h00FFFF, 1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 8'h0);
    ptr_z_i = 16'h0010;
    issue(4'd1, 2'd2, 6'd0);
    expect_ok("R4 Z", 24'h000010, 1'b0, 1'b1, 2'd2, 16'h0011, 1'b0, 8'h0);
  endtask

  task automatic t_pre;
    ptr_y_i = 16'h0000;
    issue(4'd2, 2'd1, 6'd0);
    expect_ok("R5 wrap", 24'h00FFFF, 1'b0, 1'b1, 2'd1, 16'hFFFF, 1'b0, 8'h0);
    ptr_x_i = 16'h8000;
    issue(4'd2, 2'd0, 6'd0);
    expect_ok("R5 X", 24'h007FFF, 1'b0, 1'b1, 2'd0, 16'h7FFF, 1'b0, 8'h0);
  endtask

  task automatic t_disp;
    ptr_z_i = 16'h1234;
    issue(4'd3, 2'd2, 6'd63);
    expect_ok("R6 max q", 24'h001273, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0);
    ptr_y_i = 16'hFFF0;
    issue(4'd3, 2'd1, 6'h20);
    expect_ok("R6 wrap", 24'h000010, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0);
    issue(4'd3, 2'd0, 6'd1);
    expect_err("R6 X illegal");
  endtask

  task automatic t_prog_read;
    ptr_z_i = 16'hFFFF; ptr_x_i = 16'h0001; ext_i = 8'h5A;
    issue(4'd4, 2'd0, 6'd0);
    expect_ok("R7 read", 24'h00FFFF, 1'b1, 1'b0, 2'd2, 16'h0, 1'b0, 8'h0);
    issue(4'd5, 2'd3, 6'd0);
    expect_ok("R7 inc wrap R11", 24'h00FFFF, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b0, 8'h0);
  endtask

  task automatic t_ext;
    ptr_z_i = 16'hFFFF; ext_i = 8'h01;
    issue(4'd6, 2'd1, 6'd0);
    expect_ok("R8 read", 24'h01FFFF, 1'b1, 1'b0, 2'd2, 16'h0, 1'b0, 8'h0);
    issue(4'd7, 2'd1, 6'd0);
    expect_ok("R8 carry", 24'h01FFFF, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b1, 8'h02);
    ext_i = 8'hFF;
    issue(4'd7, 2'd0, 6'd0);
    expect_ok("R8 full wrap", 24'hFFFFFF, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b1, 8'h00);
    ptr_z_i = 16'h1000; ext_i = 8'h3C;
    issue(4'd7, 2'd2, 6'd0);
    expect_ok("R8 no carry", 24'h3C1000, 1'b1, 1'b1, 2'd2, 16'h1001, 1'b1, 8'h3C);
  endtask

  task automatic t_store;
    ptr_z_i = 16'hFFFE; ext_i = 8'h03;
    issue(4'd8, 2'd0, 6'd0);
    expect_ok("R9 wrap", 24'h03FFFE, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b0, 8'h0);
    ptr_z_i = 16'h1235; ext_i = 8'h00;
    issue(4'd8, 2'd1, 6'd0);
    expect_ok("R9 odd", 24'h001234, 1'b1, 1'b1, 2'd2, 16'h1237, 1'b0, 8'h0);
  endtask

  task automatic t_reserved;
    for (int m = 9; m < 16; m++) begin
      issue(4'(m), 2'd2, 6'd0);
      expect_err("R10 reserved mode");
    end
  endtask

  initial begin
    fork
      begin
        @(negedge clk_i);
        t_reset; t_pulse; t_plain; t_post; t_pre; t_disp;
        t_prog_read; t_ext; t_store; t_reserved;
      end
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule